// File: doc/BRIEF.md
# Speculative Memory Access Gate

The gate sits between a load/store issue stage and the memory request port. For every tagged memory operation offered on the issue side it decides whether the request may be sent early, while it is still speculative, or whether it must wait until the pipeline declares it commitable. Operations that may go early leave on the memory port one cycle after acceptance, flagged as speculative. All other operations are parked in a small pending buffer.

Each parked entry runs its own three-state machine. `SLOT_FREE` moves to `SLOT_HELD` on allocation (transition *park*). `SLOT_HELD` moves to `SLOT_GO` when a commit port names its tag (transition *commit*). It returns to `SLOT_FREE` on a matching cancel or on flush-all (transition *drop*). `SLOT_GO` returns to `SLOT_FREE` either when the entry is sent to memory (transition *issue*) or when it is dropped in the same way. Two commit ports allow more than one entry to reach `SLOT_GO` in the same cycle. An age matrix then sends the oldest of them first, one per cycle.

The hold rule covers several cases: volatile locations, pages with the side-effect bit, atomic operations, stores to noncacheable targets, and accesses through the forced-order alternate spaces 0x15 and 0x1D. Everything else may be sent early. This includes noncacheable loads to nonvolatile locations and cacheable stores, which go out as ownership prefetches.

Top module: `spec_mem_gate`

## Requirements
- R1: An operation with `in_volatile`, `in_side_effect` or `in_atomic` set is parked and produces no memory request until committed. A request flagged speculative never carries `mem_atomic`.
- R2: A store (`in_store`=1) with `in_cacheable`=1 is sent early. A store with `in_cacheable`=0 is parked.
- R3: A non-store operation with `in_cacheable`=0 and `in_volatile`=0 (no other hold condition) is sent early.
- R4: With `in_alt_en`=1 and `in_asi` equal to 0x15 or 0x1D the operation is parked. Any other `in_asi` value, or `in_alt_en`=0, does not cause parking by itself.
- R5: An operation sent early appears on the memory port in the cycle after the edge that accepted it, with `mem_valid`=1, `mem_spec`=1 and the same tag, address, store and atomic values.
- R6: A commit for a parked tag moves the entry to `SLOT_GO` at the next edge. The entry is issued at the following edge with `mem_spec`=0. `mem_valid` is therefore seen after the second rising edge following the commit cycle, and not after the first.
- R7: When several entries are in `SLOT_GO` together, they are issued one per cycle, oldest allocation first.
- R8: A cancel naming a parked tag frees the entry with no memory request. If a commit and a cancel for the same tag arrive in the same cycle, the cancel wins.
- R9: `flush_all` frees every parked entry at the next edge. `in_ready` is low while `flush_all` is high.
- R10: The buffer holds 4 entries. `in_ready` is low while all 4 are occupied or while any entry is in `SLOT_GO`. An operation is accepted only when `in_valid` and `in_ready` are both high at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue side offers an operation |
| in_ready | output | 1 | Gate can take an operation this cycle |
| in_tag | input | 4 | Operation tag |
| in_addr | input | 16 | Operation address |
| in_volatile | input | 1 | Target location is volatile |
| in_side_effect | input | 1 | Target page has the side-effect bit |
| in_cacheable | input | 1 | Target is cacheable |
| in_store | input | 1 | Operation has store semantics |
| in_atomic | input | 1 | Operation is atomic |
| in_alt_en | input | 1 | Operation uses an alternate space identifier |
| in_asi | input | 8 | Alternate space identifier value |
| commit_valid | input | 2 | One valid bit per commit port |
| commit_tags | input | 8 | Commit tags, port p in bits [4p+3:4p] |
| cancel_valid | input | 1 | Cancel request |
| cancel_tag | input | 4 | Tag to cancel |
| flush_all | input | 1 | Drop every parked entry |
| mem_valid | output | 1 | Memory request valid (one-cycle pulse) |
| mem_tag | output | 4 | Request tag |
| mem_addr | output | 16 | Request address |
| mem_store | output | 1 | Request has store semantics |
| mem_atomic | output | 1 | Request is atomic |
| mem_spec | output | 1 | Request was sent speculatively |

## Verification
Three same-cycle collisions are exercised, each with a directed task. In the first, a commit and a cancel naming the same parked tag arrive in one cycle. The bench checks that no request appears in either of the two following cycles, and that a later commit for that tag is also silent. In the second, both commit ports fire in the same cycle for two parked entries, given in reverse age order. The bench checks that the older tag comes out first and the younger one on the next cycle, with `in_ready` held low in between. In the third, `flush_all` is raised while the buffer is full, and the bench confirms that commits for the flushed tags produce nothing.

// File: rtl/spec_gate_pkg.sv
package spec_gate_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_HELD = 2'd1,
        SLOT_GO   = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic store;
        logic atomic;
    } op_kind_t;

endpackage

// File: rtl/spec_gate_classify.sv
module spec_gate_classify #(
    parameter int          ASI_W       = 8,
    parameter logic [7:0]  FORCED_ASI0 = 8'h15,
    parameter logic [7:0]  FORCED_ASI1 = 8'h1D
) (
    input  logic             volatile_i,
    input  logic             side_effect_i,
    input  logic             cacheable_i,
    input  logic             store_i,
    input  logic             atomic_i,
    input  logic             alt_en_i,
    input  logic [ASI_W-1:0] asi_i,
    output logic             hold_o
);
    logic forced_order;
    logic loc_unsafe;
    logic store_no_own;

    always_comb begin
        forced_order = alt_en_i &&
                       ((asi_i == ASI_W'(FORCED_ASI0)) || (asi_i == ASI_W'(FORCED_ASI1)));
        loc_unsafe   = volatile_i || side_effect_i;
        store_no_own = store_i && !cacheable_i;
        hold_o       = loc_unsafe || atomic_i || store_no_own || forced_order;
    end

endmodule

// File: rtl/spec_gate_slot.sv
module spec_gate_slot
    import spec_gate_pkg::*;
#(
    parameter int TAG_W   = 4,
    parameter int ADDR_W  = 16,
    parameter int NCOMMIT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_i,
    input  logic [TAG_W-1:0]         tag_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  op_kind_t                 kind_i,
    input  logic [NCOMMIT-1:0]       commit_valid_i,
    input  logic [NCOMMIT*TAG_W-1:0] commit_tags_i,
    input  logic                     cancel_valid_i,
    input  logic [TAG_W-1:0]         cancel_tag_i,
    input  logic                     flush_i,
    input  logic                     issue_i,
    output logic                     busy_o,
    output logic                     go_o,
    output logic                     eligible_o,
    output logic [TAG_W-1:0]         tag_o,
    output logic [ADDR_W-1:0]        addr_o,
    output op_kind_t                 kind_o
);
    slot_state_e       st_q, st_d;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q;
    op_kind_t          kind_q;
    logic              commit_hit;
    logic              kill;

    always_comb begin
        commit_hit = 1'b0;
        for (int p = 0; p < NCOMMIT; p++) begin
            if (commit_valid_i[p] && (commit_tags_i[p*TAG_W +: TAG_W] == tag_q))
                commit_hit = 1'b1;
        end
        kill = flush_i || (cancel_valid_i && (cancel_tag_i == tag_q));
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_FREE: if (alloc_i) st_d = SLOT_HELD;
            SLOT_HELD: begin
                if (kill)            st_d = SLOT_FREE;
                else if (commit_hit) st_d = SLOT_GO;
            end
            SLOT_GO:   if (kill || issue_i) st_d = SLOT_FREE;
            default:   st_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT_FREE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            addr_q <= '0;
            kind_q <= '0;
        end else if (alloc_i && st_q == SLOT_FREE) begin
            tag_q  <= tag_i;
            addr_q <= addr_i;
            kind_q <= kind_i;
        end
    end

    always_comb begin
        busy_o     = (st_q != SLOT_FREE);
        go_o       = (st_q == SLOT_GO);
        eligible_o = (st_q == SLOT_GO) && !kill;
        tag_o      = tag_q;
        addr_o     = addr_q;
        kind_o     = kind_q;
    end

    assert_go_never_reparks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_GO) |=> (st_q != SLOT_HELD));

    assert_issue_only_from_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> (st_q == SLOT_GO));

endmodule

// File: rtl/spec_gate_age.sv
module spec_gate_age #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] alloc_i,
    input  logic [DEPTH-1:0] eligible_i,
    output logic [DEPTH-1:0] grant_o
);
    logic [DEPTH-1:0] older_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (alloc_i[i])      older_q[i][j] <= 1'b0;
                    else if (alloc_i[j]) older_q[i][j] <= 1'b1;
                end
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_pick
            logic beaten;
            always_comb begin
                beaten = 1'b0;
                for (int j = 0; j < DEPTH; j++) begin
                    if (j != gi && eligible_i[j] && older_q[j][gi]) beaten = 1'b1;
                end
                grant_o[gi] = eligible_i[gi] && !beaten;
            end
        end
    endgenerate

    assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_when_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|eligible_i) |-> (|grant_o));

    assert_single_alloc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_i));

endmodule

// File: rtl/spec_mem_gate.sv
module spec_mem_gate
    import spec_gate_pkg::*;
#(
    parameter int TAG_W   = 4,
    parameter int ADDR_W  = 16,
    parameter int ASI_W   = 8,
    parameter int DEPTH   = 4,
    parameter int NCOMMIT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [TAG_W-1:0]         in_tag,
    input  logic [ADDR_W-1:0]        in_addr,
    input  logic                     in_volatile,
    input  logic                     in_side_effect,
    input  logic                     in_cacheable,
    input  logic                     in_store,
    input  logic                     in_atomic,
    input  logic                     in_alt_en,
    input  logic [ASI_W-1:0]         in_asi,
    input  logic [NCOMMIT-1:0]       commit_valid,
    input  logic [NCOMMIT*TAG_W-1:0] commit_tags,
    input  logic                     cancel_valid,
    input  logic [TAG_W-1:0]         cancel_tag,
    input  logic                     flush_all,
    output logic                     mem_valid,
    output logic [TAG_W-1:0]         mem_tag,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_store,
    output logic                     mem_atomic,
    output logic                     mem_spec
);
    logic              hold;
    logic              accept;
    op_kind_t          in_kind;
    logic [DEPTH-1:0]  busy, go, eligible, grant, alloc;
    logic [TAG_W-1:0]  slot_tag  [DEPTH];
    logic [ADDR_W-1:0] slot_addr [DEPTH];
    op_kind_t          slot_kind [DEPTH];

    logic [TAG_W-1:0]  pick_tag;
    logic [ADDR_W-1:0] pick_addr;
    op_kind_t          pick_kind;

    spec_gate_classify #(.ASI_W(ASI_W)) u_class (
        .volatile_i   (in_volatile),
        .side_effect_i(in_side_effect),
        .cacheable_i  (in_cacheable),
        .store_i      (in_store),
        .atomic_i     (in_atomic),
        .alt_en_i     (in_alt_en),
        .asi_i        (in_asi),
        .hold_o       (hold)
    );

    always_comb begin
        in_kind.store  = in_store;
        in_kind.atomic = in_atomic;
        in_ready       = !(&busy) && !(|go) && !flush_all;
        accept         = in_valid && in_ready;
    end

    always_comb begin
        logic found;
        found = 1'b0;
        alloc = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && !busy[i] && accept && hold) begin
                alloc[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    genvar gs;
    generate
        for (gs = 0; gs < DEPTH; gs++) begin : g_slot
            spec_gate_slot #(
                .TAG_W  (TAG_W),
                .ADDR_W (ADDR_W),
                .NCOMMIT(NCOMMIT)
            ) u_slot (
                .clk           (clk),
                .rst_n         (rst_n),
                .alloc_i       (alloc[gs]),
                .tag_i         (in_tag),
                .addr_i        (in_addr),
                .kind_i        (in_kind),
                .commit_valid_i(commit_valid),
                .commit_tags_i (commit_tags),
                .cancel_valid_i(cancel_valid),
                .cancel_tag_i  (cancel_tag),
                .flush_i       (flush_all),
                .issue_i       (grant[gs]),
                .busy_o        (busy[gs]),
                .go_o          (go[gs]),
                .eligible_o    (eligible[gs]),
                .tag_o         (slot_tag[gs]),
                .addr_o        (slot_addr[gs]),
                .kind_o        (slot_kind[gs])
            );
        end
    endgenerate

    spec_gate_age #(.DEPTH(DEPTH)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_i   (alloc),
        .eligible_i(eligible),
        .grant_o   (grant)
    );

    always_comb begin
        pick_tag  = '0;
        pick_addr = '0;
        pick_kind = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i]) begin
                pick_tag  = pick_tag  | slot_tag[i];
                pick_addr = pick_addr | slot_addr[i];
                pick_kind = pick_kind | slot_kind[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid  <= 1'b0;
            mem_tag    <= '0;
            mem_addr   <= '0;
            mem_store  <= 1'b0;
            mem_atomic <= 1'b0;
            mem_spec   <= 1'b0;
        end else if (|grant) begin
            mem_valid  <= 1'b1;
            mem_tag    <= pick_tag;
            mem_addr   <= pick_addr;
            mem_store  <= pick_kind.store;
            mem_atomic <= pick_kind.atomic;
            mem_spec   <= 1'b0;
        end else if (accept && !hold) begin
            mem_valid  <= 1'b1;
            mem_tag    <= in_tag;
            mem_addr   <= in_addr;
            mem_store  <= in_store;
            mem_atomic <= in_atomic;
            mem_spec   <= 1'b1;
        end else begin
            mem_valid  <= 1'b0;
            mem_spec   <= 1'b0;
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> !in_ready);

    assert_spec_never_atomic_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_spec) |-> !mem_atomic);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (busy == '0));

    assert_nonspec_from_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> (mem_valid && !mem_spec));

endmodule

// File: tb/sim_spec_mem_gate.sv
`timescale 1ns/1ps
module sim_spec_mem_gate;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready;
    logic [3:0]  in_tag;
    logic [15:0] in_addr;
    logic        in_volatile, in_side_effect, in_cacheable, in_store, in_atomic, in_alt_en;
    logic [7:0]  in_asi;
    logic [1:0]  commit_valid;
    logic [7:0]  commit_tags;
    logic        cancel_valid;
    logic [3:0]  cancel_tag;
    logic        flush_all;
    logic        mem_valid;
    logic [3:0]  mem_tag;
    logic [15:0] mem_addr;
    logic        mem_store, mem_atomic, mem_spec;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    spec_mem_gate u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_addr(in_addr), .in_volatile(in_volatile),
        .in_side_effect(in_side_effect), .in_cacheable(in_cacheable),
        .in_store(in_store), .in_atomic(in_atomic), .in_alt_en(in_alt_en),
        .in_asi(in_asi), .commit_valid(commit_valid), .commit_tags(commit_tags),
        .cancel_valid(cancel_valid), .cancel_tag(cancel_tag), .flush_all(flush_all),
        .mem_valid(mem_valid), .mem_tag(mem_tag), .mem_addr(mem_addr),
        .mem_store(mem_store), .mem_atomic(mem_atomic), .mem_spec(mem_spec)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // drive an operation, let one edge accept it, return at the next negedge
    task automatic send_op(input logic [3:0] tag, input logic [15:0] addr,
                           input logic vol, input logic se, input logic cach,
                           input logic st, input logic at, input logic alt,
                           input logic [7:0] asi);
        in_valid = 1'b1; in_tag = tag; in_addr = addr;
        in_volatile = vol; in_side_effect = se; in_cacheable = cach;
        in_store = st; in_atomic = at; in_alt_en = alt; in_asi = asi;
        step();
        in_valid = 1'b0;
    endtask

    task automatic commit2(input logic [1:0] v, input logic [3:0] t0, input logic [3:0] t1);
        commit_valid = v; commit_tags = {t1, t0};
        step();
        commit_valid = 2'b00;
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R10 reset ready", 32'(in_ready), 32'd1);
        chk(mem_valid == 1'b0, "R5 reset idle", 32'(mem_valid), 32'd0);
    endtask

    task automatic t_early();
        send_op(4'd1, 16'h1000, 0, 0, 1, 0, 0, 0, 8'h00);
        chk(mem_valid && mem_spec && mem_tag == 4'd1 && mem_addr == 16'h1000,
            "R5 cacheable load early", 32'({mem_valid, mem_spec, mem_tag}), 32'h31);
        send_op(4'd2, 16'h2000, 0, 0, 0, 0, 0, 0, 8'h00);
        chk(mem_valid && mem_spec && mem_tag == 4'd2,
            "R3 noncacheable load early", 32'({mem_valid, mem_spec, mem_tag}), 32'h32);
        send_op(4'd3, 16'h3000, 0, 0, 1, 1, 0, 0, 8'h00);
        chk(mem_valid && mem_spec && mem_store && mem_tag == 4'd3,
            "R2 cacheable store early", 32'({mem_valid, mem_spec, mem_store}), 32'h7);
        send_op(4'd4, 16'h4000, 0, 0, 1, 0, 0, 1, 8'h16);
        chk(mem_valid && mem_spec && mem_tag == 4'd4,
            "R4 other asi early", 32'({mem_valid, mem_spec, mem_tag}), 32'h34);
        send_op(4'd5, 16'h5000, 0, 0, 1, 0, 0, 0, 8'h15);
        chk(mem_valid && mem_spec && mem_tag == 4'd5,
            "R4 asi ignored without alt enable", 32'({mem_valid, mem_spec, mem_tag}), 32'h35);
        step();
        chk(mem_valid == 1'b0, "R5 single pulse", 32'(mem_valid), 32'd0);
    endtask

    task automatic t_parked(input string req, input logic [3:0] tag,
                            input logic vol, input logic se, input logic cach,
                            input logic st, input logic at, input logic alt,
                            input logic [7:0] asi);
        send_op(tag, {12'hA00, tag}, vol, se, cach, st, at, alt, asi);
        chk(mem_valid == 1'b0, {req, " parked"}, 32'(mem_valid), 32'd0);
        commit2(2'b01, tag, 4'd0);
        chk(mem_valid == 1'b0, "R6 not after first edge", 32'(mem_valid), 32'd0);
        step();
        chk(mem_valid && !mem_spec && mem_tag == tag && mem_addr == {12'hA00, tag}
            && mem_atomic == at && mem_store == st,
            {req, " R6 issued after commit"},
            32'({mem_valid, mem_spec, mem_tag}), 32'({2'b10, tag}));
    endtask

    task automatic t_oldest();
        send_op(4'd5, 16'h0500, 1, 0, 1, 0, 0, 0, 8'h00);
        send_op(4'd9, 16'h0900, 1, 0, 1, 0, 0, 0, 8'h00);
        commit2(2'b11, 4'd9, 4'd5);
        chk(in_ready == 1'b0, "R10 ready low while committed pending", 32'(in_ready), 32'd0);
        step();
        chk(mem_valid && mem_tag == 4'd5, "R7 oldest first",
            32'({mem_valid, mem_tag}), 32'h15);
        chk(in_ready == 1'b0, "R10 ready low second pending", 32'(in_ready), 32'd0);
        step();
        chk(mem_valid && mem_tag == 4'd9, "R7 younger next",
            32'({mem_valid, mem_tag}), 32'h19);
        chk(in_ready == 1'b1, "R10 ready back", 32'(in_ready), 32'd1);
    endtask

    task automatic t_cancel();
        send_op(4'd3, 16'h0300, 0, 1, 1, 0, 0, 0, 8'h00);
        commit_valid = 2'b01; commit_tags = {4'd0, 4'd3};
        cancel_valid = 1'b1; cancel_tag = 4'd3;
        step();
        commit_valid = 2'b00; cancel_valid = 1'b0;
        chk(mem_valid == 1'b0, "R8 cancel beats commit c1", 32'(mem_valid), 32'd0);
        step();
        chk(mem_valid == 1'b0, "R8 cancel beats commit c2", 32'(mem_valid), 32'd0);
        commit2(2'b01, 4'd3, 4'd0);
        step();
        chk(mem_valid == 1'b0, "R8 cancelled tag silent", 32'(mem_valid), 32'd0);
        send_op(4'd4, 16'h0400, 0, 0, 1, 1, 1, 0, 8'h00);
        cancel_valid = 1'b1; cancel_tag = 4'd4;
        step();
        cancel_valid = 1'b0;
        commit2(2'b01, 4'd4, 4'd0);
        step();
        chk(mem_valid == 1'b0, "R8 plain cancel", 32'(mem_valid), 32'd0);
    endtask

    task automatic t_flush();
        for (int k = 0; k < 4; k++)
            send_op(4'(10 + k), 16'(16'h0B00 + k), 1, 0, 1, 0, 0, 0, 8'h00);
        chk(in_ready == 1'b0, "R10 full stalls", 32'(in_ready), 32'd0);
        flush_all = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R9 ready low during flush", 32'(in_ready), 32'd0);
        step();
        flush_all = 1'b0;
        #0.1;
        chk(in_ready == 1'b1, "R9 buffer emptied", 32'(in_ready), 32'd1);
        commit2(2'b11, 4'd10, 4'd11);
        step();
        chk(mem_valid == 1'b0, "R9 flushed tags silent a", 32'(mem_valid), 32'd0);
        commit2(2'b11, 4'd12, 4'd13);
        step();
        chk(mem_valid == 1'b0, "R9 flushed tags silent b", 32'(mem_valid), 32'd0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_tag = '0; in_addr = '0;
        in_volatile = 0; in_side_effect = 0; in_cacheable = 0; in_store = 0;
        in_atomic = 0; in_alt_en = 0; in_asi = '0;
        commit_valid = '0; commit_tags = '0; cancel_valid = 0; cancel_tag = '0;
        flush_all = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_early();
        t_parked("R1 volatile",    4'd6, 1, 0, 1, 0, 0, 0, 8'h00);
        t_parked("R1 side effect", 4'd7, 0, 1, 1, 0, 0, 0, 8'h00);
        t_parked("R1 atomic",      4'd8, 0, 0, 1, 1, 1, 0, 8'h00);
        t_parked("R2 nc store",    4'd9, 0, 0, 0, 1, 0, 0, 8'h00);
        t_parked("R4 asi 15",      4'd10, 0, 0, 1, 0, 0, 1, 8'h15);
        t_parked("R4 asi 1D",      4'd11, 0, 0, 1, 0, 0, 1, 8'h1D);
        t_oldest();
        t_cancel();
        t_flush();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule